// File: doc/BRIEF.md
# Dot-Clock LCD Timing Generator

This block produces the raster timing for a parallel RGB panel driven by a pixel (dot) clock. It runs a horizontal pixel counter and a vertical line counter. From them it derives horizontal sync, vertical sync and data enable, each with its own polarity. It also derives the pixel coordinates of the active window, a strobe at the start of each active line, and a one-clock frame-start pulse. A downstream pixel path uses the coordinates, the line strobe and the current frame base address to fetch pixels.

The timing is set by combined wait counts rather than separate porch values. The horizontal wait is back porch plus sync width, and the vertical wait is back porch plus sync width in lines. Timing fields and the frame base address are taken into shadow copies only when a frame begins, so writes made mid-frame never disturb the picture on screen. A run request starts the raster only when the sync outputs are enabled. Withdrawing the request starts a graceful stop: the raster keeps going until the downstream path reports no pending pixel data, and only then does the block go idle.

Top module: `lcdt_timing_gen`

## Requirements
- R1: While idle (run_o low) both counters are zero, pix_x_o and pix_y_o are 0, frame_start_o and line_stb_o are low, and hsync_o, vsync_o and de_o sit at their inactive levels; run_o is low after reset.
- R2: The block leaves idle on the clock after run_req_i and sync_en_i are both high; with sync_en_i low a run request is ignored. The first running cycle is a frame start at pixel (0,0).
- R3: A line lasts line_cfg_i[17:0] clocks, and hsync is active for the first HSW clocks of every line. HSW is line_cfg_i[31:18] when HSW_WIDE=1 and line_cfg_i[31:24] when HSW_WIDE=0.
- R4: A frame lasts vper_i lines. With vs_lines_i=1, vsync is active for the first vsw_i lines of the frame; with vs_lines_i=0 it is active for the first vsw_i clocks after the frame start.
- R5: Data enable is active when the pixel counter h satisfies hwait_i <= h < hwait_i+hvalid_i and the line counter v satisfies vwait_i <= v < vwait_i+vact_i. During that window pix_x_o = h-hwait_i and pix_y_o = v-vwait_i; outside it both are 0.
- R6: pol_i[0], pol_i[1] and pol_i[2] select active-high (1) or active-low (0) for hsync, vsync and data enable; inactive means the inverse level. pol_i[3] appears on dclk_fall_o and selects falling-edge data launch.
- R7: frame_start_o is high for exactly one clock each time the line counter wraps to the top of a frame. cur_base_o shows next_base_i as sampled at that wrap during the frame-start clock and holds it unchanged until the next frame start.
- R8: All timing fields, including the sync widths and the unit select, are sampled only at frame start. A change made mid-frame takes effect from the next frame.
- R9: When run_req_i drops, run_o stays high and the raster keeps counting while pix_pending_i is high. On the clock after pix_pending_i is seen low in that state, run_o falls and the outputs return to the idle state.
- R10: line_stb_o pulses on the first data-enable pixel of each active line (pix_x_o = 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst | input | 1 | Synchronous active-high reset |
| run_req_i | input | 1 | Run request level |
| sync_en_i | input | 1 | Sync outputs enabled; required for start |
| pix_pending_i | input | 1 | Downstream still holds pixel data |
| line_cfg_i | input | 32 | Line period [17:0] and hsync width field |
| hwait_i | input | 18 | Clocks from line start to first active pixel |
| hvalid_i | input | 18 | Valid pixels per line |
| vper_i | input | 18 | Frame period in lines |
| vsw_i | input | 18 | Vsync width (lines or clocks) |
| vwait_i | input | 18 | Lines from frame start to first active line |
| vact_i | input | 18 | Active lines per frame |
| vs_lines_i | input | 1 | Vsync width unit: 1 lines, 0 clocks |
| pol_i | input | 4 | Polarity selects and falling-edge launch bit |
| next_base_i | input | ADDR_W | Next frame base address |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data enable |
| dclk_fall_o | output | 1 | Launch pixel data on falling edge |
| pix_x_o | output | 18 | Active pixel column |
| pix_y_o | output | 18 | Active pixel row |
| line_stb_o | output | 1 | First valid pixel of an active line |
| frame_start_o | output | 1 | One-clock frame start pulse |
| cur_base_o | output | ADDR_W | Current frame base address |
| run_o | output | 1 | Raster running |

## Verification
The bench builds two copies side by side, one with HSW_WIDE=1 and one with HSW_WIDE=0, both with ADDR_W=32. Both see the same line period and the same sync width packed into their own field, so a wrong bit position in either variant shows up on its hsync. Small random porch and active sizes keep each frame under two hundred clocks. Several whole frames, both vsync unit modes, every polarity combination and mid-frame writes to the sync width and base address therefore fit in a short run.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;

    localparam int CNT_W = 18;
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } lcdt_state_e;

    typedef struct packed {
        logic [CNT_W-1:0] hper;
        logic [CNT_W-1:0] hsw;
        logic [CNT_W-1:0] hwait;
        logic [CNT_W-1:0] hvalid;
        logic [CNT_W-1:0] vper;
        logic [CNT_W-1:0] vsw;
        logic [CNT_W-1:0] vwait;
        logic [CNT_W-1:0] vact;
        logic             vs_lines;
    } lcdt_cfg_t;

    // drive level for an active indication under a given polarity
    function automatic logic lvl(input logic act, input logic high);
        return ~(act ^ high);
    endfunction

endpackage

// File: rtl/lcdt_axis.sv
module lcdt_axis
    import lcdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             step,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] pulse_w,
    input  logic [CNT_W-1:0] win_start,
    input  logic [CNT_W-1:0] win_len,
    output logic [CNT_W-1:0] cnt,
    output logic             at_end,
    output logic             in_pulse,
    output logic             in_win,
    output logic             at_win_start
);
    logic [CNT_W:0] win_stop;

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (step)
            cnt <= at_end ? '0 : cnt + CNT_ONE;
    end

    assign win_stop     = {1'b0, win_start} + {1'b0, win_len};
    assign at_end       = (cnt == period - CNT_ONE);
    assign in_pulse     = (cnt < pulse_w);
    assign in_win       = (cnt >= win_start) && ({1'b0, cnt} < win_stop);
    assign at_win_start = (cnt == win_start);
endmodule

// File: rtl/lcdt_ctrl.sv
module lcdt_ctrl
    import lcdt_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run_req,
    input  logic              sync_en,
    input  logic              pix_pending,
    input  logic              h_end,
    input  logic              v_end,
    input  lcdt_cfg_t         cfg_in,
    input  logic [ADDR_W-1:0] next_base,
    output lcdt_cfg_t         cfg,
    output logic [ADDR_W-1:0] cur_base,
    output logic              run,
    output logic              stop,
    output logic [CNT_W-1:0]  fclk
);
    lcdt_state_e state, state_nx;
    logic start, wrap, load;

    always_comb begin
        state_nx = state;
        case (state)
            ST_IDLE:  if (run_req && sync_en) state_nx = ST_RUN;
            ST_RUN:   if (!run_req)           state_nx = ST_DRAIN;
            ST_DRAIN: if (!pix_pending)       state_nx = ST_IDLE;
            default:                          state_nx = ST_IDLE;
        endcase
    end

    assign run   = (state != ST_IDLE);
    assign stop  = (state == ST_DRAIN) && !pix_pending;
    assign start = (state == ST_IDLE) && run_req && sync_en;
    assign wrap  = run && h_end && v_end;
    assign load  = start || (wrap && !stop);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cfg      <= '0;
            cur_base <= '0;
        end else begin
            state <= state_nx;
            if (load) begin
                cfg      <= cfg_in;
                cur_base <= next_base;
            end
        end
    end

    // clocks since frame start, saturating, for clock-unit vsync
    always_ff @(posedge clk) begin
        if (rst || !run || stop || wrap)
            fclk <= '0;
        else if (fclk != {CNT_W{1'b1}})
            fclk <= fclk + CNT_ONE;
    end
endmodule

// File: rtl/lcdt_timing_gen.sv
module lcdt_timing_gen
    import lcdt_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter bit HSW_WIDE = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run_req_i,
    input  logic              sync_en_i,
    input  logic              pix_pending_i,
    input  logic [31:0]       line_cfg_i,
    input  logic [17:0]       hwait_i,
    input  logic [17:0]       hvalid_i,
    input  logic [17:0]       vper_i,
    input  logic [17:0]       vsw_i,
    input  logic [17:0]       vwait_i,
    input  logic [17:0]       vact_i,
    input  logic              vs_lines_i,
    input  logic [3:0]        pol_i,
    input  logic [ADDR_W-1:0] next_base_i,
    output logic              hsync_o,
    output logic              vsync_o,
    output logic              de_o,
    output logic              dclk_fall_o,
    output logic [17:0]       pix_x_o,
    output logic [17:0]       pix_y_o,
    output logic              line_stb_o,
    output logic              frame_start_o,
    output logic [ADDR_W-1:0] cur_base_o,
    output logic              run_o
);
    lcdt_cfg_t        cfg_in, cfg;
    logic [CNT_W-1:0] hsw_in, hcnt, vcnt, fclk;
    logic             run, stop, clr;
    logic             h_end, h_pulse, h_win, h_first;
    logic             v_end, v_pulse, v_win, v_first_unused;
    logic             vs_act, de_act;

    generate
        if (HSW_WIDE) begin : g_hsw_wide
            assign hsw_in = CNT_W'(line_cfg_i[31:18]);
        end else begin : g_hsw_narrow
            logic gap_unused;
            assign gap_unused = ^line_cfg_i[23:18];
            assign hsw_in     = CNT_W'(line_cfg_i[31:24]);
        end
    endgenerate

    assign cfg_in = '{hper: line_cfg_i[17:0], hsw: hsw_in, hwait: hwait_i,
                      hvalid: hvalid_i, vper: vper_i, vsw: vsw_i,
                      vwait: vwait_i, vact: vact_i, vs_lines: vs_lines_i};

    lcdt_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
        .clk(clk), .rst(rst), .run_req(run_req_i), .sync_en(sync_en_i),
        .pix_pending(pix_pending_i), .h_end(h_end), .v_end(v_end),
        .cfg_in(cfg_in), .next_base(next_base_i), .cfg(cfg),
        .cur_base(cur_base_o), .run(run), .stop(stop), .fclk(fclk)
    );

    assign clr = !run || stop;

    lcdt_axis h_axis_i (
        .clk(clk), .rst(rst), .clr(clr), .step(1'b1),
        .period(cfg.hper), .pulse_w(cfg.hsw),
        .win_start(cfg.hwait), .win_len(cfg.hvalid),
        .cnt(hcnt), .at_end(h_end), .in_pulse(h_pulse),
        .in_win(h_win), .at_win_start(h_first)
    );

    lcdt_axis v_axis_i (
        .clk(clk), .rst(rst), .clr(clr), .step(h_end),
        .period(cfg.vper), .pulse_w(cfg.vsw),
        .win_start(cfg.vwait), .win_len(cfg.vact),
        .cnt(vcnt), .at_end(v_end), .in_pulse(v_pulse),
        .in_win(v_win), .at_win_start(v_first_unused)
    );

    assign vs_act = cfg.vs_lines ? v_pulse : (fclk < cfg.vsw);
    assign de_act = run && h_win && v_win;

    assign hsync_o       = lvl(run && h_pulse, pol_i[0]);
    assign vsync_o       = lvl(run && vs_act, pol_i[1]);
    assign de_o          = lvl(de_act, pol_i[2]);
    assign dclk_fall_o   = pol_i[3];
    assign pix_x_o       = de_act ? hcnt - cfg.hwait : '0;
    assign pix_y_o       = de_act ? vcnt - cfg.vwait : '0;
    assign line_stb_o    = de_act && h_first;
    assign frame_start_o = run && (hcnt == '0) && (vcnt == '0);
    assign run_o         = run;
endmodule

// File: rtl/lcdt_chk.sv
module lcdt_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              run_req_i,
    input logic              sync_en_i,
    input logic              pix_pending_i,
    input logic [3:0]        pol_i,
    input logic              hsync_o,
    input logic              de_o,
    input logic [17:0]       pix_x_o,
    input logic              line_stb_o,
    input logic              frame_start_o,
    input logic [ADDR_W-1:0] cur_base_o,
    input logic              run_o
);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !run_o |-> (!frame_start_o && !line_stb_o &&
                    hsync_o == !pol_i[0] && de_o == !pol_i[2]));

    // R2
    start_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (!run_o && !sync_en_i) |=> !run_o);

    // R7
    fs_single_chk: assert property (@(posedge clk) disable iff (rst)
        frame_start_o |=> !frame_start_o);

    // R7
    base_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !frame_start_o |-> $stable(cur_base_o));

    // R9
    drain_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (run_o && !run_req_i && pix_pending_i) |=> run_o);

    // R10
    line_stb_chk: assert property (@(posedge clk) disable iff (rst)
        line_stb_o |-> (de_o == pol_i[2] && pix_x_o == '0));
endmodule

bind lcdt_timing_gen lcdt_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk(clk), .rst(rst), .run_req_i(run_req_i), .sync_en_i(sync_en_i),
    .pix_pending_i(pix_pending_i), .pol_i(pol_i), .hsync_o(hsync_o),
    .de_o(de_o), .pix_x_o(pix_x_o), .line_stb_o(line_stb_o),
    .frame_start_o(frame_start_o), .cur_base_o(cur_base_o), .run_o(run_o)
);

// File: tb/lcdt_timing_gen_tb_top.sv
module lcdt_timing_gen_tb_top;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run_req = 1'b0, sync_en = 1'b0, pend = 1'b0;
    logic [31:0] lcfg_w, lcfg_n;
    logic [17:0] hwait = '0, hvalid = '0, vper = '0, vsw = '0, vwait = '0, vact = '0;
    logic        vlines = 1'b1;
    logic [3:0]  pol = 4'b0111;
    logic [31:0] nbase = '0;
    logic [17:0] hp = 18'd4, hsw = 18'd1;

    logic        hs, vs, de, dfall, lstb, fs, run;
    logic [17:0] px, py;
    logic [31:0] cbase;
    logic        hs_n, vs_n, de_n, dfall_n, lstb_n, fs_n, run_n;
    logic [17:0] px_n, py_n;
    logic [31:0] cbase_n;

    int checks = 0;
    int errors = 0;

    assign lcfg_w = {hsw[13:0], hp};
    assign lcfg_n = {hsw[7:0], 6'b0, hp};

    always #(CLK_P/2) clk = ~clk;

    lcdt_timing_gen #(.ADDR_W(32), .HSW_WIDE(1'b1)) dut_i (
        .clk(clk), .rst(rst), .run_req_i(run_req), .sync_en_i(sync_en),
        .pix_pending_i(pend), .line_cfg_i(lcfg_w), .hwait_i(hwait),
        .hvalid_i(hvalid), .vper_i(vper), .vsw_i(vsw), .vwait_i(vwait),
        .vact_i(vact), .vs_lines_i(vlines), .pol_i(pol), .next_base_i(nbase),
        .hsync_o(hs), .vsync_o(vs), .de_o(de), .dclk_fall_o(dfall),
        .pix_x_o(px), .pix_y_o(py), .line_stb_o(lstb), .frame_start_o(fs),
        .cur_base_o(cbase), .run_o(run)
    );

    lcdt_timing_gen #(.ADDR_W(32), .HSW_WIDE(1'b0)) dut_n (
        .clk(clk), .rst(rst), .run_req_i(run_req), .sync_en_i(sync_en),
        .pix_pending_i(pend), .line_cfg_i(lcfg_n), .hwait_i(hwait),
        .hvalid_i(hvalid), .vper_i(vper), .vsw_i(vsw), .vwait_i(vwait),
        .vact_i(vact), .vs_lines_i(vlines), .pol_i(pol), .next_base_i(nbase),
        .hsync_o(hs_n), .vsync_o(vs_n), .de_o(de_n), .dclk_fall_o(dfall_n),
        .pix_x_o(px_n), .pix_y_o(py_n), .line_stb_o(lstb_n), .frame_start_o(fs_n),
        .cur_base_o(cbase_n), .run_o(run_n)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic lv(input bit act, input logic high);
        return act ? high : ~high;
    endfunction

    task automatic check_idle(input string tag);
        chk({tag, " R1 run"}, run, 0);
        chk({tag, " R1 hsync"}, hs, lv(0, pol[0]));
        chk({tag, " R1 vsync"}, vs, lv(0, pol[1]));
        chk({tag, " R1 de"}, de, lv(0, pol[2]));
        chk({tag, " R1 xy"}, {px, py}, 0);
        chk({tag, " R1 fs"}, fs, 0);
        chk({tag, " R6 dclk_fall"}, dfall, pol[3]);
    endtask

    task automatic scenario(input int n);
        int hbp, hfp, vbp, vfp, vswl, fr, ncyc, t, m_hsw;
        logic [31:0] m_base;
        hsw    = 18'($urandom_range(1, 4));
        hbp    = $urandom_range(0, 3);
        hvalid = 18'($urandom_range(1, 8));
        hfp    = $urandom_range(1, 3);
        hwait  = 18'(hbp) + hsw;
        hp     = hwait + hvalid + 18'(hfp);
        vswl   = $urandom_range(1, 2);
        vbp    = $urandom_range(0, 2);
        vact   = 18'($urandom_range(1, 4));
        vfp    = $urandom_range(0, 2);
        vwait  = 18'(vbp + vswl);
        vper   = vwait + vact + 18'(vfp);
        vlines = n[0];
        vsw    = vlines ? 18'(vswl) : 18'($urandom_range(1, 2 * int'(hp)));
        pol    = 4'(n);
        nbase  = $urandom;
        fr     = int'(hp) * int'(vper);
        ncyc   = 2 * fr + fr / 2;
        run_req = 1'b1; sync_en = 1'b1; pend = 1'b0;
        m_hsw  = 0; m_base = '0;
        @(negedge clk);
        t = 0;
        while (run) begin
            int h, v, ft;
            bit efs, ehs, evs, ede;
            h = t % int'(hp);
            v = (t / int'(hp)) % int'(vper);
            ft = t % fr;
            efs = (ft == 0);
            if (efs) begin m_hsw = int'(hsw); m_base = nbase; end
            ehs = h < m_hsw;
            evs = vlines ? (v < int'(vsw)) : (ft < int'(vsw));
            ede = h >= int'(hwait) && h < int'(hwait + hvalid) &&
                  v >= int'(vwait) && v < int'(vwait + vact);
            // R2 R7
            chk("R7 frame_start", fs, efs);
            chk("R7 cur_base", cbase, m_base);
            // R3 R8
            chk("R3 hsync wide", hs, lv(ehs, pol[0]));
            chk("R3 hsync narrow", hs_n, lv(ehs, pol[0]));
            // R4 R6
            chk("R4 vsync", vs, lv(evs, pol[1]));
            // R5 R6
            chk("R5 de", de, lv(ede, pol[2]));
            chk("R5 pix_x", px, ede ? h - int'(hwait) : 0);
            chk("R5 pix_y", py, ede ? v - int'(vwait) : 0);
            // R10
            chk("R10 line_stb", lstb, ede && h == int'(hwait));
            chk("R9 run", run, 1);
            // mid-frame writes (R8 sync width, R7 base)
            if (t == fr / 2 || t == fr + fr / 3) begin
                hsw   = 18'($urandom_range(1, int'(hwait)));
                nbase = $urandom;
            end
            if (t == ncyc) begin run_req = 1'b0; pend = 1'b1; end
            if (t == ncyc + 4) pend = 1'b0;
            if (t > ncyc + 10) break;
            t++;
            @(negedge clk);
        end
        // R9: drained at t = ncyc+5, idle from that sample on
        chk("R9 stop cycle", t, ncyc + 5);
        check_idle("after stop");
    endtask

    initial begin
        #(CLK_P * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        hwait = 18'd1; hvalid = 18'd2; vper = 18'd3; vsw = 18'd1;
        vwait = 18'd1; vact = 18'd1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_idle("reset");
        // R2: request without sync enable is ignored
        run_req = 1'b1; sync_en = 1'b0;
        repeat (5) @(negedge clk);
        chk("R2 blocked run", run, 0);
        chk("R2 blocked hsync", hs, lv(0, pol[0]));
        run_req = 1'b0;
        @(negedge clk);
        for (int n = 0; n < 16; n++) begin
            scenario(n);
            @(negedge clk);
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule